// File: doc/BRIEF.md
# Next Program Counter Unit

This unit decides where a core fetches next and what return address a linking jump stores. The core mixes 16-bit and 32-bit instructions. Decode supplies the current pc, a flag that marks the instruction as 16-bit, a control class and a comparison code. It also supplies two register operands, a base register value and an already sign-extended offset. In the same cycle the unit returns the next pc, the link value, a taken flag and a misaligned-target flag.

The unit is purely combinational and has no clock or reset. When it sits in a pipeline stage, its outputs are registered by the surrounding stage. A parameter decides whether 16-bit instructions exist. When they do not, every step is 4 bytes, and a taken target that is not 4-byte aligned raises the misaligned flag. Choosing the destination register of a link, for example x1 for the short jump-and-link, stays with decode. This unit only supplies the value that is written.

Top module: `next_pc_unit`

## Requirements
- R1: With class 0 (sequential), taken_o is 0 and next_pc_o is pc_i+4 when short_i is 0, or pc_i+2 when short_i is 1.
- R2: link_o is pc_i+4 for a full-length instruction and pc_i+2 for a short one, for every control class.
- R3: With class 1 (conditional branch), the cmp_i codes are 0 equal, 1 not-equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal, each comparing src_a_i with src_b_i. When the comparison holds, taken_o is 1 and next_pc_o is pc_i + 2*offset_i.
- R4: cmp_i codes 2 (equal zero) and 3 (not-equal zero) compare src_a_i with zero, and src_b_i has no effect on the result.
- R5: A conditional branch whose comparison fails gives taken_o 0 and next_pc_o equal to the sequential step of R1.
- R6: With class 2 (direct jump), taken_o is 1 and next_pc_o is pc_i + 2*offset_i, with offset_i in signed two-byte units.
- R7: With class 3 (register jump), taken_o is 1 and next_pc_o is base_i + offset_i (a byte offset) with bit 0 forced to 0.
- R8: With COMPRESSED=1, misalign_o is always 0.
- R9: With COMPRESSED=0, short_i has no effect: the step and the link are always 4. misalign_o is 1 exactly when taken_o is 1 and bit 1 of the taken target is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Current program counter |
| short_i | input | 1 | Current instruction is 16 bits long |
| ctl_i | input | 2 | Control class: 0 sequential, 1 branch, 2 jump, 3 register jump |
| cmp_i | input | 3 | Branch comparison code |
| src_a_i | input | XLEN | First compared register operand |
| src_b_i | input | XLEN | Second compared register operand |
| base_i | input | XLEN | Base register for a register jump |
| offset_i | input | XLEN | Sign-extended offset (two-byte units for pc-relative, bytes for register jump) |
| next_pc_o | output | XLEN | Next program counter |
| link_o | output | XLEN | Return address for a linking jump |
| taken_o | output | 1 | Control transfer taken |
| misalign_o | output | 1 | Taken target is not 4-byte aligned in a core without 16-bit instructions |

## Verification
The branch comparisons are tried with operand pairs in which the signed and unsigned orders disagree (a negative value against a small positive one). These pairs separate the signed codes from the unsigned ones. Equal operands separate the strict codes from the or-equal codes. The zero-compare codes are driven with a nonzero second operand, which would flip the result if that operand were used. Negative offsets and an odd register-jump sum show sign handling and the clearing of bit 0. A second instance without 16-bit support, given a target with bit 1 set, tells the aligned case apart from the misaligned one.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    CTL_SEQ     = 2'd0,
    CTL_BRANCH  = 2'd1,
    CTL_JUMP    = 2'd2,
    CTL_REGJUMP = 2'd3
  } ctl_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_EQZ = 3'd2,
    CMP_NEZ = 3'd3,
    CMP_LT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_LTU = 3'd6,
    CMP_GEU = 3'd7
  } cmp_e;
endpackage

// File: rtl/npc_compare.sv
module npc_compare #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cmp_i,
  input  logic [XLEN-1:0] lhs_i,
  input  logic [XLEN-1:0] rhs_i,
  output logic            hold_o
);
  import npc_pkg::*;

  logic [XLEN-1:0] rhs_eff;
  logic            is_eq;
  logic            is_lt;
  logic            is_ltu;
  logic            zero_form;

  // codes 2 and 3 compare against zero and drop the second operand
  assign zero_form = (cmp_i[2:1] == 2'b01);
  assign rhs_eff   = zero_form ? '0 : rhs_i;
  assign is_eq     = (lhs_i == rhs_eff);
  assign is_lt     = ($signed(lhs_i) < $signed(rhs_eff));
  assign is_ltu    = (lhs_i < rhs_eff);

  always_comb begin
    unique case (cmp_e'(cmp_i))
      CMP_EQ, CMP_EQZ: hold_o = is_eq;
      CMP_NE, CMP_NEZ: hold_o = !is_eq;
      CMP_LT:          hold_o = is_lt;
      CMP_GE:          hold_o = !is_lt;
      CMP_LTU:         hold_o = is_ltu;
      CMP_GEU:         hold_o = !is_ltu;
      default:         hold_o = 1'b0;
    endcase
  end

  always_comb begin
    if (zero_form && lhs_i == '0) begin
      AST_ZERO_FORM_EQ: assert (hold_o == !cmp_i[0]); // R4
    end
  end
endmodule

// File: rtl/npc_step.sv
module npc_step #(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            short_i,
  output logic [XLEN-1:0] seq_o
);
  localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(4);
  localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);

  generate
    if (COMPRESSED) begin : g_mixed
      assign seq_o = pc_i + (short_i ? STEP_SHORT : STEP_FULL);
    end else begin : g_word
      logic unused_short;
      assign unused_short = short_i;
      assign seq_o = pc_i + STEP_FULL;
    end
  endgenerate
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic            use_reg_i,
  output logic [XLEN-1:0] target_o
);
  localparam logic [XLEN-1:0] CLR_BIT0 = {{(XLEN-1){1'b1}}, 1'b0};

  logic [XLEN-1:0] rel_target;
  logic [XLEN-1:0] reg_sum;

  // pc-relative offsets count half-words; register offsets count bytes
  assign rel_target = pc_i + {offset_i[XLEN-2:0], 1'b0};
  assign reg_sum    = base_i + offset_i;
  assign target_o   = use_reg_i ? (reg_sum & CLR_BIT0) : rel_target;

  always_comb begin
    if (use_reg_i) begin
      AST_REG_TARGET_EVEN: assert (target_o[0] == 1'b0); // R7
    end
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            short_i,
  input  logic [1:0]      ctl_i,
  input  logic [2:0]      cmp_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] offset_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            taken_o,
  output logic            misalign_o
);
  import npc_pkg::*;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] target;
  logic            cond_hold;
  logic            is_branch;
  logic            is_jump;

  npc_step #(.XLEN(XLEN), .COMPRESSED(COMPRESSED)) u_step (
    .pc_i    (pc_i),
    .short_i (short_i),
    .seq_o   (seq_pc)
  );

  npc_compare #(.XLEN(XLEN)) u_compare (
    .cmp_i  (cmp_i),
    .lhs_i  (src_a_i),
    .rhs_i  (src_b_i),
    .hold_o (cond_hold)
  );

  npc_target #(.XLEN(XLEN)) u_target (
    .pc_i      (pc_i),
    .base_i    (base_i),
    .offset_i  (offset_i),
    .use_reg_i (ctl_e'(ctl_i) == CTL_REGJUMP),
    .target_o  (target)
  );

  assign is_branch = (ctl_e'(ctl_i) == CTL_BRANCH);
  assign is_jump   = (ctl_e'(ctl_i) == CTL_JUMP) || (ctl_e'(ctl_i) == CTL_REGJUMP);
  assign taken_o   = is_jump || (is_branch && cond_hold);
  assign next_pc_o = taken_o ? target : seq_pc;
  assign link_o    = seq_pc;

  generate
    if (COMPRESSED) begin : g_mis_off
      assign misalign_o = 1'b0;
    end else begin : g_mis_on
      assign misalign_o = taken_o && target[1];
    end
  endgenerate

  always_comb begin
    if (ctl_e'(ctl_i) == CTL_SEQ) begin
      AST_SEQ_NOT_TAKEN: assert (!taken_o); // R1
    end
    AST_LINK_STEP: assert ((link_o - pc_i == XLEN'(4)) || (link_o - pc_i == XLEN'(2))); // R2
    if (is_branch && !taken_o) begin
      AST_FALLTHROUGH_LINK: assert (next_pc_o == link_o); // R5
    end
    if (is_jump) begin
      AST_JUMP_TAKEN: assert (taken_o); // R6
    end
    if (ctl_e'(ctl_i) == CTL_REGJUMP) begin
      AST_REGJUMP_EVEN: assert (next_pc_o[0] == 1'b0); // R7
    end
    if (misalign_o) begin
      AST_MISALIGN_TAKEN: assert (taken_o && !COMPRESSED); // R8
    end
  end
endmodule

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [XLEN-1:0] pc, src_a, src_b, base, offset;
  logic            short_f;
  logic [1:0]      ctl;
  logic [2:0]      cmp;
  logic [XLEN-1:0] next_pc, link, w_next_pc, w_link;
  logic            taken, misalign, w_taken, w_misalign;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  next_pc_unit #(.XLEN(XLEN), .COMPRESSED(1'b1)) i_next_pc_unit (
    .pc_i(pc), .short_i(short_f), .ctl_i(ctl), .cmp_i(cmp),
    .src_a_i(src_a), .src_b_i(src_b), .base_i(base), .offset_i(offset),
    .next_pc_o(next_pc), .link_o(link), .taken_o(taken), .misalign_o(misalign)
  );

  next_pc_unit #(.XLEN(XLEN), .COMPRESSED(1'b0)) i_next_pc_unit_word (
    .pc_i(pc), .short_i(short_f), .ctl_i(ctl), .cmp_i(cmp),
    .src_a_i(src_a), .src_b_i(src_b), .base_i(base), .offset_i(offset),
    .next_pc_o(w_next_pc), .link_o(w_link), .taken_o(w_taken), .misalign_o(w_misalign)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [XLEN-1:0] p, input logic s, input logic [1:0] c,
                       input logic [2:0] k, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] bs, input logic [XLEN-1:0] off);
    @(negedge clk);
    pc = p; short_f = s; ctl = c; cmp = k;
    src_a = a; src_b = b; base = bs; offset = off;
    #1;
  endtask

  task automatic t_idle;
    apply('0, 1'b0, 2'd0, 3'd0, '0, '0, '0, '0);
    check("R1 idle next", next_pc, 32'h4);
    check("R1 idle taken", {31'b0, taken}, '0);
    check("R8 idle misalign", {31'b0, misalign}, '0);
  endtask

  task automatic t_sequential;
    apply(32'h1000, 1'b0, 2'd0, 3'd0, 32'h5, 32'h5, '0, 32'h40);
    check("R1 seq full next", next_pc, 32'h1004);
    check("R2 seq full link", link, 32'h1004);
    apply(32'h1002, 1'b1, 2'd0, 3'd0, '0, '0, '0, '0);
    check("R1 seq short next", next_pc, 32'h1004);
    check("R2 seq short link", link, 32'h1004);
    check("R1 seq short taken", {31'b0, taken}, '0);
  endtask

  task automatic t_branch_codes;
    logic [XLEN-1:0] neg = 32'hFFFF_FFF0;
    logic [XLEN-1:0] pos = 32'h0000_0010;
    logic [XLEN-1:0] off = 32'h0000_0020;
    logic [XLEN-1:0] tgt = 32'h2000 + 32'h40;
    logic [XLEN-1:0] fall = 32'h2004;
    // neg < pos signed, neg > pos unsigned
    apply(32'h2000, 1'b0, 2'd1, 3'd4, neg, pos, '0, off);
    check("R3 blt signed taken", next_pc, tgt);
    apply(32'h2000, 1'b0, 2'd1, 3'd6, neg, pos, '0, off);
    check("R5 bltu unsigned fall", next_pc, fall);
    check("R5 bltu taken", {31'b0, taken}, '0);
    apply(32'h2000, 1'b0, 2'd1, 3'd5, neg, pos, '0, off);
    check("R5 bge signed fall", next_pc, fall);
    apply(32'h2000, 1'b0, 2'd1, 3'd7, neg, pos, '0, off);
    check("R3 bgeu unsigned taken", next_pc, tgt);
    // equal operands: ge taken, lt not
    apply(32'h2000, 1'b0, 2'd1, 3'd5, pos, pos, '0, off);
    check("R3 bge equal taken", next_pc, tgt);
    apply(32'h2000, 1'b0, 2'd1, 3'd6, pos, pos, '0, off);
    check("R5 bltu equal fall", next_pc, fall);
    apply(32'h2000, 1'b0, 2'd1, 3'd0, pos, pos, '0, off);
    check("R3 beq taken", next_pc, tgt);
    check("R3 beq taken flag", {31'b0, taken}, 32'h1);
    apply(32'h2000, 1'b0, 2'd1, 3'd1, pos, pos, '0, off);
    check("R5 bne fall", next_pc, fall);
    apply(32'h2000, 1'b0, 2'd1, 3'd1, pos, neg, '0, 32'hFFFF_FFFC);
    check("R3 bne backward", next_pc, 32'h2000 - 32'h8);
  endtask

  task automatic t_branch_zero;
    apply(32'h3000, 1'b1, 2'd1, 3'd2, '0, 32'h7, '0, 32'h10);
    check("R4 beqz ignores b taken", next_pc, 32'h3020);
    apply(32'h3000, 1'b1, 2'd1, 3'd3, '0, 32'h7, '0, 32'h10);
    check("R4 bnez zero fall by 2", next_pc, 32'h3002);
    apply(32'h3000, 1'b1, 2'd1, 3'd3, 32'h1, 32'h1, '0, 32'h10);
    check("R4 bnez nonzero taken", next_pc, 32'h3020);
    apply(32'h3000, 1'b1, 2'd1, 3'd2, 32'h1, 32'h1, '0, 32'h10);
    check("R5 beqz nonzero fall short", next_pc, 32'h3002);
  endtask

  task automatic t_jumps;
    apply(32'h4000, 1'b0, 2'd2, 3'd1, '0, '0, '0, 32'hFFFF_FF00);
    check("R6 jal backward", next_pc, 32'h4000 - 32'h200);
    check("R6 jal taken", {31'b0, taken}, 32'h1);
    check("R2 jal link full", link, 32'h4004);
    apply(32'h4000, 1'b1, 2'd2, 3'd0, '0, '0, '0, 32'h3);
    check("R6 short jal fwd", next_pc, 32'h4006);
    check("R2 short jal link", link, 32'h4002);
    apply(32'h4000, 1'b0, 2'd3, 3'd0, '0, '0, 32'h8001, 32'h0000_0004);
    check("R7 jalr clear bit0", next_pc, 32'h8004);
    apply(32'h4000, 1'b1, 2'd3, 3'd0, '0, '0, 32'h8000, 32'hFFFF_FFFF);
    check("R7 jalr neg odd", next_pc, 32'h7FFE);
    check("R2 short jalr link", link, 32'h4002);
    check("R8 no misalign when mixed", {31'b0, misalign}, '0);
  endtask

  task automatic t_word_only;
    apply(32'h5000, 1'b1, 2'd0, 3'd0, '0, '0, '0, '0);
    check("R9 word step ignores short", w_next_pc, 32'h5004);
    check("R9 word link ignores short", w_link, 32'h5004);
    apply(32'h5000, 1'b0, 2'd2, 3'd0, '0, '0, '0, 32'h1);
    check("R9 jump to +2 misalign", {31'b0, w_misalign}, 32'h1);
    check("R8 mixed same jump aligned", {31'b0, misalign}, '0);
    apply(32'h5000, 1'b0, 2'd2, 3'd0, '0, '0, '0, 32'h2);
    check("R9 jump to +4 aligned", {31'b0, w_misalign}, '0);
    apply(32'h5000, 1'b0, 2'd3, 3'd0, '0, '0, 32'h6, '0);
    check("R9 regjump bit1 misalign", {31'b0, w_misalign}, 32'h1);
    apply(32'h5000, 1'b0, 2'd1, 3'd1, 32'h1, 32'h1, '0, 32'h1);
    check("R9 not taken no misalign", {31'b0, w_misalign}, '0);
  endtask

  initial begin
    pc = '0; short_f = 1'b0; ctl = '0; cmp = '0;
    src_a = '0; src_b = '0; base = '0; offset = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_sequential();
    t_branch_codes();
    t_branch_zero();
    t_jumps();
    t_word_only();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule